// File: doc/BRIEF.md
# Down-Counting Compare Timer

A 32-bit timer peripheral that software drives over a simple synchronous register bus. A prescaler divides the clock. On every prescaled tick the counter steps down by one. When a tick brings the counter onto the value held in the compare register, the block sets a sticky event flag. That flag can raise an interrupt, and the same event can toggle, clear or set an output pin.

To schedule an event N ticks ahead, software reads the counter and writes that value minus N into the compare register. When the counter passes zero it either wraps to all ones (free-run) or reloads from the load register (periodic). A control bit lets a load-register write also overwrite the counter at once. A second control bit decides whether enabling the timer resumes from the held count or restarts from the load value. A self-clearing soft-reset bit returns the whole block to its reset state.

Top module: `dcmp_timer`

## Requirements
- R1: After `rst_n` is sampled low, every register reads zero, and `irq_o` and `pin_o` are low.
- R2: Register offsets are: control 0x00, status 0x04, load 0x08, compare 0x0C, counter 0x10. Reads return the addressed register in the same cycle. The control word keeps only bits 0, 1, 2, 3, 15:4, 17 and 23:22 (all other bits read zero). Writes to the counter offset are ignored.
- R3: While control bit 0 (run) is 1, the counter decrements once every P+1 clock cycles, where P is control bits 15:4. The first step lands P+1 edges after the enabling write edge. While run is 0, the counter holds.
- R4: With control bit 3 (reload) set, a tick that finds the counter at zero loads it from the load register.
- R5: With control bit 3 clear, a tick that finds the counter at zero wraps it to 0xFFFFFFFF.
- R6: With control bit 17 (overwrite) set, a load-register write also copies the written value into the counter at the same edge. With bit 17 clear, the counter is unaffected.
- R7: A control write that turns run on from off, with control bit 1 (restart) set in the written word, reloads the counter from the load register. With bit 1 clear, counting resumes from the held value.
- R8: Status bit 0 is set at the edge where a tick makes the counter equal the compare value. Writing 1 to status bit 0 clears it. Writing 0 leaves it set.
- R9: `irq_o` is high exactly while status bit 0 and control bit 2 (interrupt enable) are both 1. Clearing bit 2 masks the interrupt and keeps the flag.
- R10: On each compare match, control bits 23:22 act on `pin_o`: 0 holds it unchanged, 1 toggles it, 2 drives it low, 3 drives it high.
- R11: Writing control with bit 16 set clears load, compare, counter, flag, pin and every other control bit at that edge. Bit 16 reads 1 for one cycle and then clears by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Compare interrupt, level |
| pin_o | output | 1 | Compare-driven output pin |

## Verification
Register writes take effect at the edge that samples the strobe, and reads are combinational. The bench therefore reads each register back in the low half of the cycle after the write edge. Counter steps land every P+1 edges after the enabling write, so each counter check waits a counted number of falling edges from that write and compares against the step count that number implies. Flag, interrupt and pin all change at the same edge as the counter step that reaches the compare value. Each of those checks is sampled one falling edge before that step, where the old value must still be seen, and one falling edge after it, where the new value must be seen.

// File: rtl/dct_pkg.sv
// Package: shared offsets, control-word bit positions and the pin-mode
// type of the down-counting compare timer. Assumes a data word of at
// least 24 bits, so that every control field fits.
package dct_pkg;

    // Register byte offsets (software decodes these)
    localparam int OFS_CTRL = 0;
    localparam int OFS_STAT = 4;
    localparam int OFS_LOAD = 8;
    localparam int OFS_CMP  = 12;
    localparam int OFS_CNT  = 16;

    // Control-word bit positions
    localparam int B_RUN     = 0;
    localparam int B_RESTART = 1;
    localparam int B_IRQEN   = 2;
    localparam int B_RELOAD  = 3;
    localparam int B_DIV     = 4;
    localparam int B_SRST    = 16;
    localparam int B_OVW     = 17;
    localparam int B_PINMODE = 22;

    localparam int DIV_W_DEF = 12;

    // Action applied to the output pin on a compare match
    typedef enum logic [1:0] {
        PIN_HOLD   = 2'd0,
        PIN_TOGGLE = 2'd1,
        PIN_LOW    = 2'd2,
        PIN_HIGH   = 2'd3
    } pin_mode_e;

endpackage

// File: rtl/dct_regs.sv
// Module: register file and bus decode. Holds the control, load and
// compare registers, builds the write strobes the other units need, and
// drives the combinational read mux. Assumes CNT_W >= 24.
module dct_regs
    import dct_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DIV_W  = DIV_W_DEF,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              flag_q,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              run,
    output logic              irq_en,
    output logic              reload,
    output logic [DIV_W-1:0]  div,
    output pin_mode_e         pin_mode,
    output logic              srst_q,
    output logic [CNT_W-1:0]  load_q,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              srst,
    output logic              restart,
    output logic              ovw_load,
    output logic              stat_clr
);

    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
    localparam logic [CNT_W-1:0] SRST_BIT = ONE << B_SRST;
    localparam logic [CNT_W-1:0] DIV_MASK = ((ONE << DIV_W) - ONE) << B_DIV;
    localparam logic [CNT_W-1:0] CTRL_MASK =
        (ONE << B_RUN) | (ONE << B_RESTART) | (ONE << B_IRQEN) |
        (ONE << B_RELOAD) | DIV_MASK | (ONE << B_OVW) |
        (CNT_W'(3) << B_PINMODE);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFS_LOAD);
    localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFS_CMP);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);

    logic [CNT_W-1:0] ctrl_q;
    logic wr_ctrl, wr_stat, wr_load, wr_cmp;

    // Address decode of the write strobe
    always_comb begin
        wr_ctrl = bus_we && (bus_addr == A_CTRL);
        wr_stat = bus_we && (bus_addr == A_STAT);
        wr_load = bus_we && (bus_addr == A_LOAD);
        wr_cmp  = bus_we && (bus_addr == A_CMP);
    end

    // Event strobes derived from the write in progress
    always_comb begin
        srst     = wr_ctrl && bus_wdata[B_SRST];
        restart  = wr_ctrl && !bus_wdata[B_SRST] && bus_wdata[B_RUN] &&
                   bus_wdata[B_RESTART] && !ctrl_q[B_RUN];
        ovw_load = wr_load && ctrl_q[B_OVW];
        stat_clr = wr_stat && bus_wdata[0];
    end

    // Control word: a soft-reset write leaves only the reset bit, which
    // then clears itself on the following edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            if (bus_wdata[B_SRST]) ctrl_q <= SRST_BIT;
            else                   ctrl_q <= bus_wdata & CTRL_MASK;
        end else begin
            ctrl_q <= ctrl_q & ~SRST_BIT;
        end
    end

    // Load and compare registers
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            load_q <= '0;
            cmp_q  <= '0;
        end else begin
            if (wr_load) load_q <= bus_wdata;
            if (wr_cmp)  cmp_q  <= bus_wdata;
        end
    end

    // Read mux; unmapped offsets return zero
    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_STAT:  bus_rdata = {{(CNT_W-1){1'b0}}, flag_q};
            A_LOAD:  bus_rdata = load_q;
            A_CMP:   bus_rdata = cmp_q;
            A_CNT:   bus_rdata = cnt_q;
            default: bus_rdata = '0;
        endcase
    end

    // Field extraction
    always_comb begin
        run      = ctrl_q[B_RUN];
        irq_en   = ctrl_q[B_IRQEN];
        reload   = ctrl_q[B_RELOAD];
        div      = ctrl_q[B_DIV +: DIV_W];
        pin_mode = pin_mode_e'(ctrl_q[B_PINMODE +: 2]);
        srst_q   = ctrl_q[B_SRST];
    end

endmodule

// File: rtl/dct_prescaler.sv
// Module: clock divider. Emits a one-cycle tick every DIV+1 cycles while
// run is high. The phase restarts from zero whenever run is low or a soft
// reset is written.
module dct_prescaler #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] phase_q;

    // Tick when the phase reaches the divide value
    always_comb tick = run && (phase_q == div);

    // Phase counter, wraps on each tick
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run || tick) phase_q <= '0;
        else                               phase_q <= phase_q + 1'b1;
    end

endmodule

// File: rtl/dct_counter.sv
// Module: main down-counter with reload/wrap at zero and compare detection.
// Update priority: soft reset, then restart from load, then overwrite
// from the bus, then a tick step. A match fires only on a tick step.
module dct_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    input  logic             restart,
    input  logic             ovw,
    input  logic [CNT_W-1:0] ovw_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             match
);

    logic [CNT_W-1:0] step_val;

    // Value after one tick: reload or wrap at zero, else decrement
    always_comb begin
        if (cnt_q == '0) step_val = reload ? load_val : '1;
        else             step_val = cnt_q - 1'b1;
    end

    // Compare event on a tick step landing on the compare value
    always_comb match = tick && !clr && !restart && !ovw && (step_val == cmp_val);

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (restart)  cnt_q <= load_val;
        else if (ovw)      cnt_q <= ovw_val;
        else if (tick)     cnt_q <= step_val;
    end

endmodule

// File: rtl/dct_event.sv
// Module: sticky compare flag, interrupt gating and the output-pin action.
// A match wins over a same-cycle write-one-to-clear.
module dct_event
    import dct_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      match,
    input  logic      stat_clr,
    input  logic      irq_en,
    input  pin_mode_e pin_mode,
    output logic      flag_q,
    output logic      pin_q,
    output logic      irq
);

    // Sticky event flag
    always_ff @(posedge clk) begin
        if (!rst_n || clr) flag_q <= 1'b0;
        else if (match)    flag_q <= 1'b1;
        else if (stat_clr) flag_q <= 1'b0;
    end

    // Output pin action on each match
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pin_q <= 1'b0;
        end else if (match) begin
            case (pin_mode)
                PIN_HOLD:   pin_q <= pin_q;
                PIN_TOGGLE: pin_q <= !pin_q;
                PIN_LOW:    pin_q <= 1'b0;
                PIN_HIGH:   pin_q <= 1'b1;
                default:    pin_q <= pin_q;
            endcase
        end
    end

    // Interrupt level
    always_comb irq = flag_q && irq_en;

endmodule

// File: rtl/dcmp_timer.sv
// Module: top of the down-counting compare timer. Wires the register file,
// prescaler, counter and event logic together. The bus is single-cycle:
// writes land at the sampling edge, and reads are combinational.
module dcmp_timer
    import dct_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DIV_W  = DIV_W_DEF,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              pin_o
);

    logic             run, irq_en, reload, srst_q, srst, restart, ovw_load, stat_clr;
    logic [DIV_W-1:0] div;
    pin_mode_e        pin_mode;
    logic [CNT_W-1:0] load_q, cmp_q, cnt_q;
    logic             tick, match, flag_q;

    dct_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cnt_q(cnt_q), .flag_q(flag_q),
        .bus_rdata(bus_rdata), .run(run), .irq_en(irq_en), .reload(reload),
        .div(div), .pin_mode(pin_mode), .srst_q(srst_q), .load_q(load_q),
        .cmp_q(cmp_q), .srst(srst), .restart(restart), .ovw_load(ovw_load),
        .stat_clr(stat_clr)
    );

    dct_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(srst), .div(div), .tick(tick)
    );

    dct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(srst), .tick(tick), .reload(reload),
        .load_val(load_q), .restart(restart), .ovw(ovw_load),
        .ovw_val(bus_wdata), .cmp_val(cmp_q), .cnt_q(cnt_q), .match(match)
    );

    dct_event u_evt (
        .clk(clk), .rst_n(rst_n), .clr(srst), .match(match),
        .stat_clr(stat_clr), .irq_en(irq_en), .pin_mode(pin_mode),
        .flag_q(flag_q), .pin_q(pin_o), .irq(irq_o)
    );

endmodule

// File: rtl/dct_checker.sv
// Module: temporal checks for the timer, bound into every dcmp_timer.
// Assumes that every state change outside a tick comes from a bus write.
module dct_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic             tick,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic             match,
    input logic             flag,
    input logic             pin,
    input logic             irq,
    input logic             srst_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R3: a tick from a nonzero count steps down by exactly one
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != '0 && !bus_we) |=> (cnt == $past(cnt) - ONE));

    // R3: a stopped counter holds when the bus is idle
    a_r3_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !bus_we) |=> $stable(cnt));

    // R8: only a bus write can clear the flag
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !bus_we) |=> flag);

    // R9: the interrupt never rises without the flag
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    // R10: the pin moves only on a match or a write
    a_r10_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!match && !bus_we) |=> $stable(pin));

    // R11: the soft-reset bit clears itself
    a_r11_srst_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_q && !bus_we) |=> !srst_q);

endmodule

bind dcmp_timer dct_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .tick(tick), .run(run),
    .cnt(cnt_q), .match(match), .flag(flag_q), .pin(pin_o), .irq(irq_o),
    .srst_q(srst_q)
);

// File: tb/tb_dcmp_timer.sv
module tb_dcmp_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_LOAD = 5'h08,
                           A_CMP = 5'h0C, A_CNT = 5'h10;
    localparam logic [31:0] C_RUN = 32'h1, C_RESTART = 32'h2, C_IRQEN = 32'h4,
                            C_RELOAD = 32'h8, C_SRST = 32'h1_0000, C_OVW = 32'h2_0000,
                            C_TOG = 32'h40_0000, C_LOW = 32'h80_0000, C_HIGH = 32'hC0_0000;

    // Vector: {div[12], load[32], reload[1], cycles[16], expected count[32]}
    localparam int NV = 7;
    localparam logic [92:0] VEC [NV] = '{
        {12'd0, 32'd10,         1'b0, 16'd5,  32'd5},
        {12'd3, 32'd100,        1'b0, 16'd20, 32'd95},
        {12'd0, 32'd3,          1'b1, 16'd4,  32'd3},
        {12'd0, 32'd3,          1'b0, 16'd4,  32'hFFFF_FFFF},
        {12'd1, 32'd2,          1'b1, 16'd9,  32'd1},
        {12'd0, 32'd0,          1'b0, 16'd2,  32'hFFFF_FFFE},
        {12'd7, 32'hFFFF_FFFF,  1'b0, 16'd80, 32'hFFFF_FFF5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, pin_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dcmp_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .pin_o(pin_o)
    );

    always #(CLK_PERIOD/2) clk = !clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One-cycle write; returns at the falling edge after the write edge
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_reg("R1 ctrl", A_CTRL, 0);
        chk_reg("R1 status", A_STAT, 0);
        chk_reg("R1 load", A_LOAD, 0);
        chk_reg("R1 compare", A_CMP, 0);
        chk_reg("R1 counter", A_CNT, 0);
        chk("R1 irq", {31'd0, irq_o}, 0);
        chk("R1 pin", {31'd0, pin_o}, 0);

        // Table walk: R3 prescaling, R4 reload, R5 wrap
        for (int i = 0; i < NV; i++) begin
            bus_write(A_CTRL, C_SRST);
            bus_write(A_CTRL, C_OVW);
            bus_write(A_LOAD, VEC[i][80:49]);
            bus_write(A_CTRL, C_RUN | (VEC[i][48] ? C_RELOAD : 32'd0) |
                              ({20'd0, VEC[i][92:81]} << 4));
            repeat (int'(VEC[i][47:32])) @(negedge clk);
            chk_reg(VEC[i][48] ? "R3/R4 table" : "R3/R5 table", A_CNT, VEC[i][31:0]);
        end
        bus_write(A_CTRL, C_SRST);

        // R2 readback masking and read-only counter
        bus_write(A_CTRL, 32'hFFFE_FFFE);
        chk_reg("R2 ctrl mask", A_CTRL, 32'h00C2_FFFE);
        bus_write(A_CTRL, 0);
        bus_write(A_LOAD, 32'h1234_5678);
        chk_reg("R2 load", A_LOAD, 32'h1234_5678);
        chk_reg("R6 no overwrite", A_CNT, 0);
        bus_write(A_CMP, 32'hCAFE_F00D);
        chk_reg("R2 compare", A_CMP, 32'hCAFE_F00D);
        bus_write(A_CNT, 32'h55);
        chk_reg("R2 counter read-only", A_CNT, 0);
        chk_reg("R2 unmapped", 5'h14, 0);

        // R6 overwrite on load write
        bus_write(A_CTRL, C_OVW);
        bus_write(A_LOAD, 32'h777);
        chk_reg("R6 overwrite", A_CNT, 32'h777);

        // R7 resume vs restart, R3 hold while stopped
        bus_write(A_CTRL, C_RUN);
        chk_reg("R7 resume from held", A_CNT, 32'h777);
        repeat (3) @(negedge clk);
        chk_reg("R3 div0 steps", A_CNT, 32'h774);
        bus_write(A_CTRL, 0);
        repeat (5) @(negedge clk);
        chk_reg("R3 hold stopped", A_CNT, 32'h772);
        bus_write(A_CTRL, C_RUN);
        chk_reg("R7 resume", A_CNT, 32'h772);
        bus_write(A_CTRL, 0);
        bus_write(A_CTRL, C_RUN | C_RESTART);
        chk_reg("R7 restart", A_CNT, 32'h777);
        bus_write(A_CTRL, 0);

        // R8 scheduling N=5 ticks ahead, R9 interrupt masking
        bus_write(A_CTRL, C_SRST);
        bus_write(A_CTRL, C_OVW);
        bus_write(A_LOAD, 32'd1000);
        bus_write(A_CMP, 32'd995);
        bus_write(A_CTRL, C_RUN | C_IRQEN);
        repeat (4) @(negedge clk);
        chk_reg("R8 flag before match", A_STAT, 0);
        chk("R9 irq before match", {31'd0, irq_o}, 0);
        @(negedge clk);
        chk_reg("R8 flag at match", A_STAT, 1);
        chk("R9 irq at match", {31'd0, irq_o}, 1);
        bus_write(A_CTRL, C_RUN);
        chk("R9 irq masked", {31'd0, irq_o}, 0);
        chk_reg("R9 flag kept when masked", A_STAT, 1);
        bus_write(A_STAT, 0);
        chk_reg("R8 write zero no effect", A_STAT, 1);
        bus_write(A_STAT, 1);
        chk_reg("R8 write one clears", A_STAT, 0);
        bus_write(A_CTRL, 0);

        // R10 pin modes; with load 3 reload, compare 1, a match every 4 ticks
        bus_write(A_CTRL, C_SRST);
        bus_write(A_CTRL, C_OVW);
        bus_write(A_LOAD, 32'd3);
        bus_write(A_CMP, 32'd1);
        bus_write(A_CTRL, C_RUN | C_RELOAD | C_TOG);
        @(negedge clk);
        chk("R10 toggle before", {31'd0, pin_o}, 0);
        @(negedge clk);
        chk("R10 toggle first match", {31'd0, pin_o}, 1);
        repeat (3) @(negedge clk);
        chk("R10 toggle between", {31'd0, pin_o}, 1);
        @(negedge clk);
        chk("R10 toggle second match", {31'd0, pin_o}, 0);
        chk_reg("R4 periodic reload count", A_CNT, 32'd1);
        bus_write(A_CTRL, C_RUN | C_RELOAD | C_HIGH);
        repeat (4) @(negedge clk);
        chk("R10 drive high", {31'd0, pin_o}, 1);
        bus_write(A_CTRL, C_RUN | C_RELOAD | C_LOW);
        repeat (4) @(negedge clk);
        chk("R10 drive low", {31'd0, pin_o}, 0);
        bus_write(A_CTRL, C_RUN | C_RELOAD | C_HIGH);
        repeat (4) @(negedge clk);
        chk("R10 drive high again", {31'd0, pin_o}, 1);
        bus_write(A_CTRL, C_RUN | C_RELOAD);
        repeat (8) @(negedge clk);
        chk("R10 hold mode", {31'd0, pin_o}, 1);
        chk_reg("R8 flag from matches", A_STAT, 1);

        // R11 soft reset
        bus_write(A_CTRL, C_RUN | C_RELOAD | C_SRST);
        chk_reg("R11 reset bit visible", A_CTRL, C_SRST);
        chk_reg("R11 load cleared", A_LOAD, 0);
        chk_reg("R11 compare cleared", A_CMP, 0);
        chk_reg("R11 counter cleared", A_CNT, 0);
        chk_reg("R11 flag cleared", A_STAT, 0);
        chk("R11 pin cleared", {31'd0, pin_o}, 0);
        @(negedge clk);
        chk_reg("R11 self clear", A_CTRL, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule